// File: doc/BRIEF.md
# Pointer-Addressed Stack and Register Space

This block is a small byte store of `DEPTH` locations, reached through a narrow register-select bus. One select value opens a data window onto whichever location an internal pointer selects. A second select value reads or loads the pointer itself. Locations inside a configured stack range act as a LIFO:

- A data write stores the byte at the pointer and moves the pointer forward.
- A data read steps the pointer back, returns the byte found there and clears that cell.

Every location outside that range is plain static storage: a spare byte at 0, a 16-bit HL pair at 51/52, a jump address at 53/54 and a return address at 55/56. The top three locations serve as a serial mailbox: 57 is the next byte to send, 58 is the last received byte and 59 is a character-ready flag. A receive strobe fills 58 and raises the flag. Reading 58 lowers the flag again.

A controller can also nudge the pointer up or down by one with two strobes. Adding or subtracting one on the pointer is the only arithmetic in the block. Read data is combinational and is valid in the cycle `rd_en` is high. All side effects take place on the next rising clock edge.

Top module: `ptr_stack_space`

## Requirements
- R1: After reset the pointer is 0, every location is 0, `tx_byte` is 0, and `rdata` is 0 whenever `rd_en` is low or `wr_en` is high.
- R2: A write with `sel`=4 while the pointer is in 1..49 stores `wdata` at the pointer and advances the pointer by one.
- R3: A read with `sel`=4 while the pointer is in 2..50 returns the byte at pointer-1, sets the pointer to pointer-1 and clears that location to 0.
- R4: A read with `sel`=4 while the pointer is 1 returns 0 and leaves the pointer and all locations unchanged.
- R5: A write with `sel`=4 while the pointer is 50 stores `wdata` at location 50 and leaves the pointer at 50.
- R6: At locations 0 and 51..59, a `sel`=4 write stores the byte and a `sel`=4 read returns it without changing it. Neither access moves the pointer.
- R7: A read with `sel`=7 returns the pointer. A write with `sel`=7 loads the pointer with `wdata` when `wdata` < 60, and is ignored otherwise.
- R8: With no bus access in the cycle, `ptr_inc` alone raises the pointer by one and `ptr_dec` alone lowers it by one, saturating at 59 and 0. Any cycle with `wr_en` or `rd_en` high ignores both strobes.
- R9: `rx_valid` writes `rx_byte` to location 58 and 1 to location 59. A `sel`=4 read at location 58 clears location 59 to 0, unless `rx_valid` is high in the same cycle, in which case the flag stays 1.
- R10: `tx_byte` always shows the content of location 57.
- R11: `sel` values other than 4 and 7 read as 0, and writes through them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Bus register select (4 = data window, 7 = pointer) |
| wr_en | input | 1 | Bus write strobe (wins over `rd_en`) |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational |
| ptr_inc | input | 1 | Raise pointer by one |
| ptr_dec | input | 1 | Lower pointer by one |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte queued for transmit (location 57) |

## Verification
The bench uses the default parameters: 60 locations, stack 1..50, mailbox at 57..59, and selects 4 and 7. Because the stack is only 50 deep, a direct pointer load places the pointer at either end of the stack in a single access. The floor pop at 1 and the ceiling push at 50 are therefore tested next to ordinary pushes and pops. The pointer limits 0 and 59 are also reached with single loads. This lets the inc/dec saturation and the rejection of out-of-range loads be tested without long walks.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      PTR_HOLD = 2'd0,
      PTR_LOAD = 2'd1,
      PTR_UP   = 2'd2,
      PTR_DOWN = 2'd3
   } ptr_op_e;
endpackage

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
   import stk_pkg::*;
#(
   parameter int DEPTH = 60,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ptr_op_e       op,
   input  logic [AW-1:0] load_val,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else begin
         unique case (op)
            PTR_LOAD: ptr <= load_val;
            PTR_UP:   if (ptr != TOP) ptr <= ptr + 1'b1;
            PTR_DOWN: if (ptr != '0)  ptr <= ptr - 1'b1;
            default:  ptr <= ptr;
         endcase
      end
   end

   AST_PTR_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PTR_UP && ptr == TOP) |=> ptr == TOP); // R8
   AST_PTR_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PTR_DOWN && ptr == '0) |=> ptr == '0); // R8
endmodule

// File: rtl/stk_cell_array.sv
module stk_cell_array #(
   parameter int DW      = 8,
   parameter int DEPTH   = 60,
   parameter int TX_LOC  = 57,
   parameter int RX_LOC  = 58,
   parameter int RDY_LOC = 59,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          clr_en,
   input  logic [AW-1:0] clr_addr,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] tx_data
);
   logic [DW-1:0] cell_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (i == RX_LOC) begin : g_rx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cell_q[i] <= '0;
            else if (rx_valid)                         cell_q[i] <= rx_data;
            else if (wr_en && wr_addr == AW'(i))       cell_q[i] <= wr_data;
            else if (clr_en && clr_addr == AW'(i))     cell_q[i] <= '0;
         end
      end else if (i == RDY_LOC) begin : g_rdy
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cell_q[i] <= '0;
            else if (rx_valid)                         cell_q[i] <= DW'(1);
            else if (wr_en && wr_addr == AW'(i))       cell_q[i] <= wr_data;
            else if (clr_en && clr_addr == AW'(i))     cell_q[i] <= '0;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cell_q[i] <= '0;
            else if (wr_en && wr_addr == AW'(i))       cell_q[i] <= wr_data;
            else if (clr_en && clr_addr == AW'(i))     cell_q[i] <= '0;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < DEPTH; k++)
         if (rd_addr == AW'(k)) rd_data = cell_q[k];
   end

   assign tx_data = cell_q[TX_LOC];

   AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> cell_q[RDY_LOC] == DW'(1)); // R9
   AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> cell_q[RX_LOC] == $past(rx_data)); // R9
endmodule

// File: rtl/ptr_stack_space.sv
module ptr_stack_space
   import stk_pkg::*;
#(
   parameter int DW       = 8,
   parameter int SW       = 3,
   parameter int DEPTH    = 60,
   parameter int STK_LO   = 1,
   parameter int STK_HI   = 50,
   parameter int TX_LOC   = 57,
   parameter int RX_LOC   = 58,
   parameter int RDY_LOC  = 59,
   parameter int DATA_SEL = 4,
   parameter int PTR_SEL  = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] sel,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          ptr_inc,
   input  logic          ptr_dec,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_byte,
   output logic [DW-1:0] tx_byte
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LO_A  = AW'(STK_LO);
   localparam logic [AW-1:0] HI_A  = AW'(STK_HI);
   localparam logic [AW-1:0] RX_A  = AW'(RX_LOC);
   localparam logic [AW-1:0] RDY_A = AW'(RDY_LOC);

   if (STK_LO < 1 || STK_HI < STK_LO || STK_HI >= DEPTH) begin : g_bad_stack
      $error("stack range must lie inside 1..DEPTH-1");
   end
   if (RX_LOC >= DEPTH || RDY_LOC >= DEPTH || TX_LOC >= DEPTH ||
       RX_LOC <= STK_HI || RDY_LOC <= STK_HI || TX_LOC <= STK_HI) begin : g_bad_mbox
      $error("mailbox locations must be static and inside DEPTH");
   end
   if (DATA_SEL == PTR_SEL || DATA_SEL >= (1 << SW) || PTR_SEL >= (1 << SW)) begin : g_bad_sel
      $error("select codes must differ and fit SW bits");
   end
   if (AW > DW) begin : g_bad_width
      $error("pointer must fit in one data byte");
   end

   logic [AW-1:0] ptr;
   ptr_op_e       op;
   logic          data_win, ptr_win, in_stack, dwr, drd, pop_ok, push_adv, any_bus, load_ok;
   logic          clr_en;
   logic [AW-1:0] clr_addr, rd_addr;
   logic [DW-1:0] cell_rd;

   assign data_win = (sel == SW'(DATA_SEL));
   assign ptr_win  = (sel == SW'(PTR_SEL));
   assign in_stack = (ptr >= LO_A) && (ptr <= HI_A);
   assign dwr      = wr_en && data_win;
   assign drd      = rd_en && !wr_en && data_win;
   assign pop_ok   = drd && in_stack && (ptr != LO_A);
   assign push_adv = dwr && in_stack && (ptr != HI_A);
   assign any_bus  = wr_en || rd_en;
   assign load_ok  = wr_en && ptr_win && (wdata < DW'(DEPTH));

   always_comb begin
      if (load_ok)                            op = PTR_LOAD;
      else if (push_adv)                      op = PTR_UP;
      else if (pop_ok)                        op = PTR_DOWN;
      else if (!any_bus && ptr_inc && !ptr_dec) op = PTR_UP;
      else if (!any_bus && ptr_dec && !ptr_inc) op = PTR_DOWN;
      else                                    op = PTR_HOLD;
   end

   assign rd_addr  = in_stack ? ptr - 1'b1 : ptr;
   assign clr_en   = pop_ok || (drd && ptr == RX_A);
   assign clr_addr = pop_ok ? ptr - 1'b1 : RDY_A;

   stk_ptr_unit #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .load_val (wdata[AW-1:0]),
      .ptr      (ptr)
   );

   stk_cell_array #(
      .DW(DW), .DEPTH(DEPTH), .TX_LOC(TX_LOC), .RX_LOC(RX_LOC), .RDY_LOC(RDY_LOC)
   ) u_cells (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (dwr),
      .wr_addr  (ptr),
      .wr_data  (wdata),
      .clr_en   (clr_en),
      .clr_addr (clr_addr),
      .rx_valid (rx_valid),
      .rx_data  (rx_byte),
      .rd_addr  (rd_addr),
      .rd_data  (cell_rd),
      .tx_data  (tx_byte)
   );

   always_comb begin
      rdata = '0;
      if (rd_en && !wr_en) begin
         if (ptr_win)
            rdata = DW'(ptr);
         else if (data_win && !(in_stack && ptr == LO_A))
            rdata = cell_rd;
      end
   end

   AST_PUSH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && ptr >= LO_A && ptr < HI_A) |=> ptr == $past(ptr) + 1'b1); // R2
   AST_POP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (drd && ptr > LO_A && ptr <= HI_A) |=> ptr == $past(ptr) - 1'b1); // R3
   AST_POP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (drd && ptr == LO_A) |-> rdata == '0); // R4
   AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (drd && ptr == LO_A) |=> $stable(ptr)); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && ptr == HI_A) |=> ptr == HI_A); // R5
   AST_PTR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && ptr_win) |-> rdata == DW'(ptr)); // R7
endmodule

// File: tb/tb_ptr_stack_space.sv
module tb_ptr_stack_space;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_INC = 2'd2, OP_DEC = 2'd3;
   localparam int NV = 22;
   // {op[20:19], sel[18:16], data[15:8], expected[7:0]}
   localparam logic [20:0] VEC [NV] = '{
      {OP_WR, 3'd7, 8'd1,   8'd0},    // R7 load ptr 1
      {OP_WR, 3'd4, 8'h11,  8'd0},    // R2 push
      {OP_WR, 3'd4, 8'h22,  8'd0},
      {OP_WR, 3'd4, 8'h33,  8'd0},
      {OP_RD, 3'd7, 8'd0,   8'd4},    // R2 ptr advanced
      {OP_RD, 3'd4, 8'd0,   8'h33},   // R3 pop
      {OP_RD, 3'd4, 8'd0,   8'h22},   // R3 pop
      {OP_RD, 3'd7, 8'd0,   8'd2},    // R3 ptr back
      {OP_WR, 3'd7, 8'd4,   8'd0},
      {OP_RD, 3'd4, 8'd0,   8'h00},   // R3 popped cell cleared
      {OP_RD, 3'd4, 8'd0,   8'h00},   // R3 cell 2 cleared
      {OP_RD, 3'd4, 8'd0,   8'h11},   // R3
      {OP_RD, 3'd4, 8'd0,   8'h00},   // R4 floor
      {OP_RD, 3'd7, 8'd0,   8'd1},    // R4 ptr held
      {OP_WR, 3'd7, 8'd51,  8'd0},
      {OP_WR, 3'd4, 8'hAB,  8'd0},    // R6 HL low
      {OP_INC,3'd0, 8'd0,   8'd0},    // R8
      {OP_WR, 3'd4, 8'hCD,  8'd0},
      {OP_RD, 3'd4, 8'd0,   8'hCD},   // R6
      {OP_RD, 3'd4, 8'd0,   8'hCD},   // R6 non-destructive
      {OP_DEC,3'd0, 8'd0,   8'd0},    // R8
      {OP_RD, 3'd4, 8'd0,   8'hAB}    // R6
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [2:0] sel = '0;
   logic       wr_en = 0, rd_en = 0, ptr_inc = 0, ptr_dec = 0, rx_valid = 0;
   logic [7:0] wdata = '0, rx_byte = '0, rdata, tx_byte;
   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptr_stack_space dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .ptr_inc(ptr_inc), .ptr_dec(ptr_dec),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic op(input logic [1:0] kind, input logic [2:0] s, input logic [7:0] d,
                     input logic [7:0] exp, input string req);
      @(negedge clk);
      sel = s; wdata = d;
      wr_en = (kind == OP_WR); rd_en = (kind == OP_RD);
      ptr_inc = (kind == OP_INC); ptr_dec = (kind == OP_DEC);
      #1;
      if (kind == OP_RD) check(req, rdata, exp);
      @(posedge clk); #1;
      wr_en = 0; rd_en = 0; ptr_inc = 0; ptr_dec = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1;
      // R1 reset state
      check("R1 rdata idle", rdata, 8'h00);
      check("R1 tx_byte", tx_byte, 8'h00);
      op(OP_RD, 3'd7, 0, 8'd0, "R1 ptr");
      op(OP_RD, 3'd4, 0, 8'd0, "R1 cell0");

      for (int i = 0; i < NV; i++)
         op(VEC[i][20:19], VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], "R2/R3/R4/R6/R8 table");

      // R5 ceiling
      op(OP_WR, 3'd7, 8'd49, 0, "");
      op(OP_WR, 3'd4, 8'hA1, 0, "");
      op(OP_WR, 3'd4, 8'hB2, 0, "");
      op(OP_RD, 3'd7, 0, 8'd50, "R5 ptr held at 50");
      op(OP_RD, 3'd4, 0, 8'hA1, "R5 pop below ceiling");
      op(OP_WR, 3'd7, 8'd51, 0, "");
      op(OP_DEC, 0, 0, 0, "");
      op(OP_RD, 3'd7, 0, 8'd50, "R8 dec");

      // R7 out-of-range load ignored
      op(OP_WR, 3'd7, 8'd60, 0, "");
      op(OP_RD, 3'd7, 0, 8'd50, "R7 load 60 ignored");
      // R8 saturation
      op(OP_WR, 3'd7, 8'd59, 0, "");
      op(OP_INC, 0, 0, 0, "");
      op(OP_RD, 3'd7, 0, 8'd59, "R8 sat top");
      op(OP_WR, 3'd7, 8'd0, 0, "");
      op(OP_DEC, 0, 0, 0, "");
      op(OP_RD, 3'd7, 0, 8'd0, "R8 sat zero");
      // R8 inc ignored during bus access
      @(negedge clk); sel = 3'd7; rd_en = 1; ptr_inc = 1;
      @(posedge clk); #1; rd_en = 0; ptr_inc = 0;
      op(OP_RD, 3'd7, 0, 8'd0, "R8 inc ignored with bus");

      // R11 unused select
      op(OP_WR, 3'd5, 8'h3C, 0, "");
      op(OP_RD, 3'd5, 0, 8'h00, "R11 unused read");
      op(OP_RD, 3'd7, 0, 8'd0, "R11 ptr untouched");
      op(OP_RD, 3'd4, 0, 8'h00, "R11 cell0 untouched");

      // R10 tx mailbox
      op(OP_WR, 3'd7, 8'd57, 0, "");
      op(OP_WR, 3'd4, 8'h5A, 0, "");
      check("R10 tx_byte", tx_byte, 8'h5A);

      // R9 receive flow
      @(negedge clk); rx_valid = 1; rx_byte = 8'h41;
      @(posedge clk); #1; rx_valid = 0;
      op(OP_WR, 3'd7, 8'd59, 0, "");
      op(OP_RD, 3'd4, 0, 8'h01, "R9 ready set");
      op(OP_WR, 3'd7, 8'd58, 0, "");
      op(OP_RD, 3'd4, 0, 8'h41, "R9 rx byte");
      op(OP_WR, 3'd7, 8'd59, 0, "");
      op(OP_RD, 3'd4, 0, 8'h00, "R9 ready cleared");
      op(OP_WR, 3'd7, 8'd58, 0, "");
      @(negedge clk); sel = 3'd4; rd_en = 1; rx_valid = 1; rx_byte = 8'h42;
      @(posedge clk); #1; rd_en = 0; rx_valid = 0;
      op(OP_WR, 3'd7, 8'd59, 0, "");
      op(OP_RD, 3'd4, 0, 8'h01, "R9 rx wins over clear");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule